// File: doc/BRIEF.md
# Network Port Control and Status Register Block

This block is the host-facing register file and command decoder of a network controller port. The host reads and writes four 16-bit words through a small address window, using either whole-word writes or single-byte writes. Word 0 carries the command field, the interrupt enable, a software reset trigger and the pending interrupt flags. Word 1 reports the port state and a fixed device-type code. Words 2 and 3 hold the two halves of a control-block pointer.

When a command is written, the block checks it against the current port state, which is one of READY, RUNNING or HALTED. A legal command moves the port to its new state, emits any one-cycle pulse that the command calls for, and raises the done flag. An illegal command raises the error flag and leaves the state as it was. A single interrupt request line is driven from the pending flags and the enable bit. The ring engines and the function-block processor sit outside the block and see only the poll, fetch and ring-restart pulses and the latched pointer.

Top module: `portcsr_top`

## Requirements
- R1: After hardware reset, word 0 reads 0x0000, word 1 reads the type code in bits [7:4] with the READY code 2 in bits [3:0], the pointer output is 0 and `irq` is low. State codes in word 1 bits [3:0] are READY=2, RUNNING=3, HALTED=4.
- R2: Writes of any kind to word 1 (`bus_addr[2:1]`=1) leave its read value unchanged.
- R3: A byte write (`bus_byte`=1) to address 1 clears each word-0 flag in bits [15:8] whose bit in `bus_wdata[15:8]` is 1, leaving the others, and runs no command: the command field (bits [3:0]) and the port state stay the same.
- R4: A write to word 0 with bit 5 set is a software reset: word 0 returns with only done (bit 8) and the summary bit (bit 7) set and enable (bit 6) cleared, the state goes to READY, words 2 and 3 and the pointer output return to 0.
- R5: A write to word 0 whose command field equals the stored one while bit 6 differs from the stored enable only toggles the enable and sets done (bit 8); no command runs and the state is kept.
- R6: Word 2 stores its written bytes with bit 0 forced to 0; word 3 keeps only bits [1:0]. Command 1 latches the pointer output as {word3[1:0], word2} and sets done.
- R7: Command 4 (start) from READY enters RUNNING, pulses `ring_restart` for one cycle and sets done; from any other state it sets the error flag (bit 15) and keeps the state.
- R8: Command 9 (halt) from READY or RUNNING enters HALTED; command 10 (stop) from RUNNING enters READY; command 3 (self-test) from READY or HALTED enters READY. Each sets done when legal and sets error without a state change otherwise.
- R9: Command 0 sets no flag; the reserved codes 6, 7 and 11 to 15 change nothing but set done.
- R10: Word 0 bit 7 reads 1 exactly when some bit of [15:8] is set, and `irq` is high only when that summary and the enable bit 6 are both set.
- R11: Command 8 (transmit poll) and command 5 (receive poll) are legal only in RUNNING; command 8 then pulses `tx_poll` for one cycle. Command 2 pulses `get_cmd` for one cycle from any state. All three set done when legal.
- R12: `irq` drops in the same cycle that the write clearing the last pending flag takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_byte | input | 1 | 1 = byte write selected by `bus_addr[0]`, 0 = word write |
| bus_addr | input | 3 | Byte address; bits [2:1] pick the word, bit 0 picks the byte |
| bus_wdata | input | 16 | Write data; a byte write takes its data from its own lane |
| bus_rdata | output | 16 | Read data of the word picked by `bus_addr[2:1]` |
| irq | output | 1 | Interrupt request |
| blk_ptr | output | 18 | Latched control-block pointer |
| tx_poll | output | 1 | One-cycle transmit poll pulse |
| get_cmd | output | 1 | One-cycle function-block fetch pulse |
| ring_restart | output | 1 | One-cycle pulse telling the ring engines to restart at index 0 |

## Verification
The bench builds the block with the type code set to 0xA rather than its default, so the read value of word 1 proves that the code is a parameter and not a constant, and keeps the default 2-bit upper pointer width. With that width the 18-bit pointer has all bits of word 3 that survive, which brings the masking of the upper word and the forced-even low bit into one readable pointer value. Every state transition is walked from each of its legal and illegal source states, so the legality table and the one-cycle pulses are both observed at the ports.

// File: rtl/portcsr_pkg.sv
package portcsr_pkg;

    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int CMD_W      = 4;
    localparam int FLAG_W     = WORD_W - BYTE_W;

    // Bit positions inside word 0
    localparam int CTL_RESET_BIT = 5;
    localparam int CTL_IE_BIT    = 6;
    // Flag indices inside the upper byte of word 0
    localparam int FLAG_DONE_IDX = 0;
    localparam int FLAG_ERR_IDX  = 7;

    typedef enum logic [3:0] {
        PS_READY   = 4'h2,
        PS_RUNNING = 4'h3,
        PS_HALTED  = 4'h4
    } port_state_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 4'd0,
        CMD_LOAD_PTR  = 4'd1,
        CMD_GET_CMD   = 4'd2,
        CMD_SELF_TEST = 4'd3,
        CMD_START     = 4'd4,
        CMD_RX_POLL   = 4'd5,
        CMD_TX_POLL   = 4'd8,
        CMD_HALT      = 4'd9,
        CMD_STOP      = 4'd10
    } port_cmd_e;

    typedef struct packed {
        logic        set_done;
        logic        set_err;
        logic        go_state;
        port_state_e next_state;
        logic        ptr_load;
        logic        tx_poll;
        logic        get_cmd;
        logic        ring_restart;
    } cmd_result_t;

    // Legality of a command code in a given port state
    function automatic logic cmd_allowed(logic [CMD_W-1:0] cmd, port_state_e st);
        logic ok;
        case (cmd)
            CMD_START:     ok = (st == PS_READY);
            CMD_HALT:      ok = (st == PS_READY) || (st == PS_RUNNING);
            CMD_STOP:      ok = (st == PS_RUNNING);
            CMD_SELF_TEST: ok = (st != PS_RUNNING);
            CMD_RX_POLL,
            CMD_TX_POLL:   ok = (st == PS_RUNNING);
            default:       ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/portcsr_bus_dec.sv
module portcsr_bus_dec (
    input  logic       bus_wr,
    input  logic       bus_byte,
    input  logic [2:0] bus_addr,
    output logic       ctl_lo_wr,
    output logic       ctl_hi_wr,
    output logic       ptr_lo_lo_wr,
    output logic       ptr_lo_hi_wr,
    output logic       ptr_hi_wr
);
    logic [1:0] word_sel;
    logic       lane_lo;
    logic       lane_hi;

    always_comb begin
        word_sel = bus_addr[2:1];
        lane_lo  = bus_wr && (!bus_byte || !bus_addr[0]);
        lane_hi  = bus_wr && (!bus_byte ||  bus_addr[0]);

        ctl_lo_wr    = (word_sel == 2'd0) && lane_lo;
        ctl_hi_wr    = (word_sel == 2'd0) && lane_hi;
        ptr_lo_lo_wr = (word_sel == 2'd2) && lane_lo;
        ptr_lo_hi_wr = (word_sel == 2'd2) && lane_hi;
        ptr_hi_wr    = (word_sel == 2'd3) && lane_lo;
        // word 1 produces no write enable at all
    end
endmodule

// File: rtl/portcsr_cmd_exec.sv
module portcsr_cmd_exec
    import portcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctl,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic             wr_rst,
    input  logic             wr_ie,
    output logic             soft_rst,
    output logic             set_done,
    output logic             set_err,
    output logic             ptr_load,
    output logic             ie_q,
    output logic [CMD_W-1:0] cmd_q,
    output port_state_e      state_q,
    output logic             tx_poll,
    output logic             get_cmd,
    output logic             ring_restart
);
    logic        ie_toggle;
    logic        run_cmd;
    cmd_result_t res;

    always_comb begin
        soft_rst  = wr_ctl && wr_rst;
        ie_toggle = wr_ctl && !wr_rst && (wr_ie != ie_q) && (wr_cmd == cmd_q);
        run_cmd   = wr_ctl && !wr_rst && !ie_toggle;
    end

    always_comb begin
        res            = '0;
        res.next_state = state_q;
        if (run_cmd) begin
            if (!cmd_allowed(wr_cmd, state_q)) begin
                res.set_err = 1'b1;
            end else begin
                case (wr_cmd)
                    CMD_NOP: ;
                    CMD_LOAD_PTR: begin
                        res.ptr_load = 1'b1;
                        res.set_done = 1'b1;
                    end
                    CMD_GET_CMD: begin
                        res.get_cmd  = 1'b1;
                        res.set_done = 1'b1;
                    end
                    CMD_SELF_TEST: begin
                        res.go_state   = 1'b1;
                        res.next_state = PS_READY;
                        res.set_done   = 1'b1;
                    end
                    CMD_START: begin
                        res.go_state     = 1'b1;
                        res.next_state   = PS_RUNNING;
                        res.ring_restart = 1'b1;
                        res.set_done     = 1'b1;
                    end
                    CMD_TX_POLL: begin
                        res.tx_poll  = 1'b1;
                        res.set_done = 1'b1;
                    end
                    CMD_HALT: begin
                        res.go_state   = 1'b1;
                        res.next_state = PS_HALTED;
                        res.set_done   = 1'b1;
                    end
                    CMD_STOP: begin
                        res.go_state   = 1'b1;
                        res.next_state = PS_READY;
                        res.set_done   = 1'b1;
                    end
                    default: res.set_done = 1'b1; // receive poll and reserved codes
                endcase
            end
        end
    end

    always_comb begin
        set_done = res.set_done || soft_rst || ie_toggle;
        set_err  = res.set_err;
        ptr_load = res.ptr_load;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state_q      <= PS_READY;
            cmd_q        <= '0;
            ie_q         <= 1'b0;
            tx_poll      <= 1'b0;
            get_cmd      <= 1'b0;
            ring_restart <= 1'b0;
        end else begin
            tx_poll      <= res.tx_poll;
            get_cmd      <= res.get_cmd;
            ring_restart <= res.ring_restart;
            if (ie_toggle) begin
                ie_q <= wr_ie;
            end else if (run_cmd) begin
                cmd_q <= wr_cmd;
                ie_q  <= wr_ie;
                if (res.go_state) begin
                    state_q <= res.next_state;
                end
            end
        end
    end
endmodule

// File: rtl/portcsr_flags.sv
module portcsr_flags
    import portcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              clr_en,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              ie,
    output logic [FLAG_W-1:0] flags_q,
    output logic              summary,
    output logic              irq
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else if (wipe) begin
                flags_q[i] <= set_vec[i];
            end else begin
                // write-one-to-clear, a same-cycle set wins
                flags_q[i] <= (flags_q[i] && !(clr_en && clr_mask[i])) || set_vec[i];
            end
        end
    end

    always_comb begin
        summary = |flags_q;
        irq     = summary && ie;
    end
endmodule

// File: rtl/portcsr_ptr.sv
module portcsr_ptr
    import portcsr_pkg::*;
#(
    parameter int PTR_HI_W = 2,
    localparam int PTR_W   = WORD_W + PTR_HI_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wipe,
    input  logic                lo_lo_wr,
    input  logic                lo_hi_wr,
    input  logic                hi_wr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                ptr_load,
    output logic [WORD_W-1:0]   lo_q,
    output logic [PTR_HI_W-1:0] hi_q,
    output logic [PTR_W-1:0]    ptr_q
);
    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            lo_q  <= '0;
            hi_q  <= '0;
            ptr_q <= '0;
        end else begin
            if (lo_lo_wr) begin
                lo_q[BYTE_W-1:0] <= {wdata[BYTE_W-1:1], 1'b0};
            end
            if (lo_hi_wr) begin
                lo_q[WORD_W-1:BYTE_W] <= wdata[WORD_W-1:BYTE_W];
            end
            if (hi_wr) begin
                hi_q <= wdata[PTR_HI_W-1:0];
            end
            if (ptr_load) begin
                ptr_q <= {hi_q, lo_q};
            end
        end
    end
endmodule

// File: rtl/portcsr_top.sv
module portcsr_top
    import portcsr_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE = 4'h1,
    parameter int         PTR_HI_W  = 2,
    localparam int        BLK_PTR_W = WORD_W + PTR_HI_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_byte,
    input  logic [2:0]           bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 irq,
    output logic [BLK_PTR_W-1:0] blk_ptr,
    output logic                 tx_poll,
    output logic                 get_cmd,
    output logic                 ring_restart
);
    logic              ctl_lo_wr, ctl_hi_wr;
    logic              ptr_lo_lo_wr, ptr_lo_hi_wr, ptr_hi_wr;
    logic              soft_rst, set_done, set_err, ptr_load, ie_q;
    logic [CMD_W-1:0]  cmd_q;
    port_state_e       state_q;
    logic [FLAG_W-1:0] set_vec, flags_q;
    logic              summary;
    logic [WORD_W-1:0]   ptr_lo;
    logic [PTR_HI_W-1:0] ptr_hi;

    portcsr_bus_dec u_dec (
        .bus_wr       (bus_wr),
        .bus_byte     (bus_byte),
        .bus_addr     (bus_addr),
        .ctl_lo_wr    (ctl_lo_wr),
        .ctl_hi_wr    (ctl_hi_wr),
        .ptr_lo_lo_wr (ptr_lo_lo_wr),
        .ptr_lo_hi_wr (ptr_lo_hi_wr),
        .ptr_hi_wr    (ptr_hi_wr)
    );

    portcsr_cmd_exec u_exec (
        .clk          (clk),
        .rst          (rst),
        .wr_ctl       (ctl_lo_wr),
        .wr_cmd       (bus_wdata[CMD_W-1:0]),
        .wr_rst       (bus_wdata[CTL_RESET_BIT]),
        .wr_ie        (bus_wdata[CTL_IE_BIT]),
        .soft_rst     (soft_rst),
        .set_done     (set_done),
        .set_err      (set_err),
        .ptr_load     (ptr_load),
        .ie_q         (ie_q),
        .cmd_q        (cmd_q),
        .state_q      (state_q),
        .tx_poll      (tx_poll),
        .get_cmd      (get_cmd),
        .ring_restart (ring_restart)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[FLAG_DONE_IDX] = set_done;
        set_vec[FLAG_ERR_IDX]  = set_err;
    end

    portcsr_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .wipe     (soft_rst),
        .clr_en   (ctl_hi_wr),
        .clr_mask (bus_wdata[WORD_W-1:BYTE_W]),
        .set_vec  (set_vec),
        .ie       (ie_q),
        .flags_q  (flags_q),
        .summary  (summary),
        .irq      (irq)
    );

    portcsr_ptr #(.PTR_HI_W(PTR_HI_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .wipe     (soft_rst),
        .lo_lo_wr (ptr_lo_lo_wr),
        .lo_hi_wr (ptr_lo_hi_wr),
        .hi_wr    (ptr_hi_wr),
        .wdata    (bus_wdata),
        .ptr_load (ptr_load),
        .lo_q     (ptr_lo),
        .hi_q     (ptr_hi),
        .ptr_q    (blk_ptr)
    );

    always_comb begin
        case (bus_addr[2:1])
            2'd0:    bus_rdata = {flags_q, summary, ie_q, 2'b00, cmd_q};
            2'd1:    bus_rdata = {{BYTE_W{1'b0}}, TYPE_CODE, state_q};
            2'd2:    bus_rdata = ptr_lo;
            default: bus_rdata = {{(WORD_W-PTR_HI_W){1'b0}}, ptr_hi};
        endcase
    end
endmodule

// File: rtl/portcsr_chk.sv
module portcsr_chk #(
    parameter int PTR_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic [7:0]       flags,
    input logic             ie,
    input logic [3:0]       state,
    input logic             tx_poll,
    input logic             ring_restart,
    input logic [PTR_W-1:0] blk_ptr
);
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);

    a_r12_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (flags == 8'h00) |-> !irq);

    a_r11_txpoll_only_running: assert property (@(posedge clk) disable iff (rst)
        tx_poll |-> (state == 4'h3));

    a_r7_restart_only_running: assert property (@(posedge clk) disable iff (rst)
        ring_restart |-> (state == 4'h3));

    a_r7_run_entered_from_ready: assert property (@(posedge clk) disable iff (rst)
        (state == 4'h3 && $past(state) != 4'h3) |-> ($past(state) == 4'h2));

    a_r8_state_code_legal: assert property (@(posedge clk) disable iff (rst)
        (state == 4'h2) || (state == 4'h3) || (state == 4'h4));

    a_r6_ptr_even: assert property (@(posedge clk) disable iff (rst)
        blk_ptr[0] == 1'b0);
endmodule

bind portcsr_top portcsr_chk #(.PTR_W(BLK_PTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq          (irq),
    .flags        (flags_q),
    .ie           (ie_q),
    .state        (state_q),
    .tx_poll      (tx_poll),
    .ring_restart (ring_restart),
    .blk_ptr      (blk_ptr)
);

// File: tb/tb_portcsr_top.sv
module tb_portcsr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic [17:0] blk_ptr;
    logic        tx_poll, get_cmd, ring_restart;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    portcsr_top #(.TYPE_CODE(4'hA), .PTR_HI_W(2)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .blk_ptr(blk_ptr), .tx_poll(tx_poll), .get_cmd(get_cmd),
        .ring_restart(ring_restart)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // one write, landing on the next rising edge; returns at the following falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic byt);
        @(negedge clk);
        bus_wr = 1'b1; bus_byte = byt; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_word(input string tag, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(tag, {16'h0, v}, {16'h0, exp});
    endtask

    task automatic clear_flags();
        wr(3'd1, 16'hFF00, 1'b1);
    endtask

    task automatic t_reset();
        expect_word("R1 word0", 3'd0, 16'h0000);
        expect_word("R1 word1", 3'd2, 16'h00A2);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 ptr", {14'h0, blk_ptr}, 32'h0);
    endtask

    task automatic t_word1_ignored();
        wr(3'd2, 16'hFFFF, 1'b0);
        expect_word("R2 word write", 3'd2, 16'h00A2);
        wr(3'd3, 16'h5500, 1'b1);
        expect_word("R2 byte write", 3'd2, 16'h00A2);
    endtask

    task automatic t_noop_reserved();
        wr(3'd0, 16'h0000, 1'b0);
        expect_word("R9 nop no done", 3'd0, 16'h0000);
        wr(3'd0, 16'h0006, 1'b0);
        expect_word("R9 code6 done", 3'd0, 16'h0186);
        check("R10 irq needs enable", {31'h0, irq}, 32'h0);
        wr(3'd1, 16'h0100, 1'b1);
        expect_word("R3 odd byte clear", 3'd0, 16'h0006);
        expect_word("R3 state kept", 3'd2, 16'h00A2);
        wr(3'd0, 16'h000B, 1'b0);
        expect_word("R9 code11 done", 3'd0, 16'h018B);
        clear_flags();
        wr(3'd0, 16'h000F, 1'b0);
        expect_word("R9 code15 done", 3'd0, 16'h018F);
        clear_flags();
        wr(3'd0, 16'h0007, 1'b0);
        expect_word("R9 code7 done", 3'd0, 16'h0187);
        clear_flags();
    endtask

    task automatic t_start_toggle();
        wr(3'd0, 16'h000A, 1'b0);
        expect_word("R8 stop from ready err", 3'd0, 16'h808A);
        wr(3'd1, 16'h8000, 1'b1);
        expect_word("R3 err cleared", 3'd0, 16'h000A);
        wr(3'd0, 16'h0004, 1'b0);
        expect_word("R7 start done", 3'd0, 16'h0184);
        expect_word("R7 running", 3'd2, 16'h00A3);
        check("R7 restart pulse", {31'h0, ring_restart}, 32'h1);
        @(negedge clk);
        check("R7 restart one cycle", {31'h0, ring_restart}, 32'h0);
        clear_flags();
        wr(3'd0, 16'h0044, 1'b0);
        expect_word("R5 ie toggle", 3'd0, 16'h01C4);
        expect_word("R5 state kept", 3'd2, 16'h00A3);
        check("R10 irq on", {31'h0, irq}, 32'h1);
        wr(3'd1, 16'h0100, 1'b1);
        check("R12 irq off same cycle", {31'h0, irq}, 32'h0);
        expect_word("R12 word0", 3'd0, 16'h0044);
        wr(3'd0, 16'h0044, 1'b0);
        expect_word("R7 start in running err", 3'd0, 16'h80C4);
        check("R7 no restart", {31'h0, ring_restart}, 32'h0);
        clear_flags();
    endtask

    task automatic t_polls();
        wr(3'd0, 16'h0048, 1'b0);
        check("R11 tx poll pulse", {31'h0, tx_poll}, 32'h1);
        expect_word("R11 tx poll done", 3'd0, 16'h01C8);
        @(negedge clk);
        check("R11 tx poll one cycle", {31'h0, tx_poll}, 32'h0);
        clear_flags();
        wr(3'd0, 16'h0042, 1'b0);
        check("R11 get cmd pulse", {31'h0, get_cmd}, 32'h1);
        expect_word("R11 get cmd done", 3'd0, 16'h01C2);
        clear_flags();
        wr(3'd0, 16'h0045, 1'b0);
        expect_word("R11 rx poll running", 3'd0, 16'h01C5);
        clear_flags();
        wr(3'd0, 16'h004A, 1'b0);
        expect_word("R8 stop done", 3'd0, 16'h01CA);
        expect_word("R8 stop to ready", 3'd2, 16'h00A2);
        clear_flags();
        wr(3'd0, 16'h0048, 1'b0);
        check("R11 no tx poll in ready", {31'h0, tx_poll}, 32'h0);
        expect_word("R11 tx poll err", 3'd0, 16'h80C8);
        clear_flags();
        wr(3'd0, 16'h0045, 1'b0);
        expect_word("R11 rx poll err", 3'd0, 16'h80C5);
        clear_flags();
    endtask

    task automatic t_halt();
        wr(3'd0, 16'h0049, 1'b0);
        expect_word("R8 halt done", 3'd0, 16'h01C9);
        expect_word("R8 halted", 3'd2, 16'h00A4);
        clear_flags();
        wr(3'd0, 16'h0044, 1'b0);
        expect_word("R7 start from halted err", 3'd0, 16'h80C4);
        expect_word("R7 still halted", 3'd2, 16'h00A4);
        clear_flags();
        wr(3'd0, 16'h0049, 1'b0);
        expect_word("R8 halt from halted err", 3'd0, 16'h80C9);
        clear_flags();
        wr(3'd0, 16'h0043, 1'b0);
        expect_word("R8 self test done", 3'd0, 16'h01C3);
        expect_word("R8 self test ready", 3'd2, 16'h00A2);
        clear_flags();
    endtask

    task automatic t_pointer();
        wr(3'd4, 16'h1235, 1'b0);
        expect_word("R6 word2 even", 3'd4, 16'h1234);
        wr(3'd6, 16'hFFFF, 1'b0);
        expect_word("R6 word3 masked", 3'd6, 16'h0003);
        wr(3'd5, 16'hAB00, 1'b1);
        expect_word("R6 high byte", 3'd4, 16'hAB34);
        wr(3'd4, 16'h0077, 1'b1);
        expect_word("R6 low byte even", 3'd4, 16'hAB76);
        wr(3'd0, 16'h0041, 1'b0);
        check("R6 ptr latched", {14'h0, blk_ptr}, 32'h3AB76);
        expect_word("R6 load done", 3'd0, 16'h01C1);
        clear_flags();
    endtask

    task automatic t_soft_reset();
        wr(3'd0, 16'h0044, 1'b0);
        expect_word("R7 running again", 3'd2, 16'h00A3);
        clear_flags();
        wr(3'd0, 16'h0020, 1'b0);
        expect_word("R4 word0", 3'd0, 16'h0180);
        expect_word("R4 ready", 3'd2, 16'h00A2);
        expect_word("R4 word2", 3'd4, 16'h0000);
        expect_word("R4 word3", 3'd6, 16'h0000);
        check("R4 ptr", {14'h0, blk_ptr}, 32'h0);
        check("R4 irq", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word1_ignored();
        t_noop_reserved();
        t_start_toggle();
        t_polls();
        t_halt();
        t_pointer();
        t_soft_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule